// File: doc/BRIEF.md
# Ring Electrode Scan Sequencer

This block steps a ring of impedance-imaging electrodes through a full adjacent-drive, adjacent-sense acquisition. For every injecting pair of neighbouring electrodes it walks through each neighbouring sensing pair that shares no electrode with that injecting pair. It presents encoded select values for the current-injection and voltage-sensing multiplexers. It waits a programmable number of settling clocks and then issues a single-cycle measure request to the downstream demodulator. It holds the selection until the demodulator answers with a done strobe, and then moves on.

A start command begins acquisition at the first injecting pair. Frames then follow one another without a gap. A stop command is remembered and honoured only when the last reading of the current frame completes, so every frame that is begun is finished. The select indices and a frame-start flag come out with every measure request, so the demodulator can tag its result.

Top module: `eit_scan_seq`

## Requirements
- R1: After synchronous reset `busy`, `meas_start`, `frame_start`, `drv_idx` and `meas_idx` are all zero.
- R2: A `start_cmd` sampled while idle begins a frame whose first request has `drv_idx`=0 (electrodes 1 and 2 inject) and `meas_idx`=2 (sensing across electrodes 3 and 4).
- R3: Index k names the pair of zero-based electrodes k and (k+1) mod 16. For injecting pair d, the sensing pairs are taken in the order d+2, d+3, …, d+14 (mod 16). That gives 13 pairs per injecting pair, and none of them shares an electrode with the injecting pair.
- R4: After the 13th reading of injecting pair d, injecting pair d+1 (mod 16) is selected, starting at sensing pair d+3. A frame is 16 injecting pairs, or 208 readings.
- R5: With settle value S (sampled when the selection is loaded), `meas_start` is high exactly S+1 clock cycles after the clock edge that changes the selection.
- R6: `meas_start` is a one-cycle pulse. The selection advances only on a `meas_done` sampled while a measurement is outstanding. `meas_done` sampled while settling is ignored.
- R7: `frame_start` is high together with `meas_start` on the first reading of each frame (drive 0, sense 2) and low on every other reading.
- R8: Without a stop command, the reading after the frame's last one (drive 15, sense 13) starts a new frame at drive 0, sense 2.
- R9: A `stop_cmd` given during a frame does not cut the frame short. `busy` falls on the edge that accepts the done for drive 15, sense 13, and no further `meas_start` is issued.
- R10: `start_cmd` while busy and `stop_cmd` while idle have no effect.
- R11: The selection is held constant from a `meas_start` pulse until the accepted `meas_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_cmd | input | 1 | Begin acquisition (one-cycle strobe) |
| stop_cmd | input | 1 | End acquisition at the next frame boundary (strobe) |
| settle_cycles | input | SETTLE_W | Settling delay in clocks after each selection change |
| meas_done | input | 1 | Demodulator has finished the requested measurement |
| drv_idx | output | IDX_W | Injecting pair index (lower electrode, zero-based) |
| meas_idx | output | IDX_W | Sensing pair index (lower electrode, zero-based) |
| meas_start | output | 1 | One-cycle measurement request |
| frame_start | output | 1 | Marks the first request of a frame |
| busy | output | 1 | Acquisition in progress |

## Verification
The checks assume the demodulator raises `meas_done` only in response to a request. `meas_done` may arrive in the same cycle as `meas_start` or later. The commands are assumed to be single-cycle strobes. The stimulus drives every done strobe on the falling edge that follows an observed request. Where it deliberately places a stray done in the settling window, the only check is that the done has no effect. The commands are pulsed for exactly one cycle, between readings.

// File: rtl/eit_scan_pkg.sv
package eit_scan_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_WAIT   = 2'd2
  } scan_state_t;
endpackage

// File: rtl/eit_pair_step.sv
// Computes the selection that follows the current one on the electrode ring.
module eit_pair_step #(
  parameter int N_ELEC = 16,
  parameter int IDX_W  = $clog2(N_ELEC)
) (
  input  logic [IDX_W-1:0] cur_drv,
  input  logic [IDX_W-1:0] cur_meas,
  output logic [IDX_W-1:0] nxt_drv,
  output logic [IDX_W-1:0] nxt_meas,
  output logic             drive_last,
  output logic             frame_last
);
  localparam int SUM_W = IDX_W + 2;

  function automatic logic [IDX_W-1:0] ring_add(input logic [IDX_W-1:0] base, input int unsigned off);
    logic [SUM_W-1:0] s;
    s = SUM_W'(base) + SUM_W'(off);
    if (s >= SUM_W'(N_ELEC)) s = s - SUM_W'(N_ELEC);
    return s[IDX_W-1:0];
  endfunction

  logic [IDX_W-1:0] last_meas;
  logic [IDX_W-1:0] drv_plus;

  always_comb begin
    last_meas  = ring_add(cur_drv, N_ELEC - 2);
    drv_plus   = ring_add(cur_drv, 1);
    drive_last = (cur_meas == last_meas);
    frame_last = drive_last && (cur_drv == IDX_W'(N_ELEC - 1));
    if (drive_last) begin
      nxt_drv  = drv_plus;
      nxt_meas = ring_add(cur_drv, 3);
    end else begin
      nxt_drv  = cur_drv;
      nxt_meas = ring_add(cur_meas, 1);
    end
  end
endmodule

// File: rtl/eit_settle_timer.sv
// Down-counter that expires after the loaded number of running cycles.
module eit_settle_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (run && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/eit_scan_seq.sv
module eit_scan_seq #(
  parameter int N_ELEC   = 16,
  parameter int IDX_W    = $clog2(N_ELEC),
  parameter int SETTLE_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_cmd,
  input  logic                stop_cmd,
  input  logic [SETTLE_W-1:0] settle_cycles,
  input  logic                meas_done,
  output logic [IDX_W-1:0]    drv_idx,
  output logic [IDX_W-1:0]    meas_idx,
  output logic                meas_start,
  output logic                frame_start,
  output logic                busy
);
  import eit_scan_pkg::*;

  localparam logic [IDX_W-1:0] FIRST_DRV  = '0;
  localparam logic [IDX_W-1:0] FIRST_MEAS = IDX_W'(2);

  scan_state_t      state_q;
  logic             stop_pend_q;
  logic [IDX_W-1:0] nxt_drv, nxt_meas;
  logic             drive_last, frame_last;
  logic             tmr_expired;
  logic             finishing;
  logic             tmr_load;

  eit_pair_step #(.N_ELEC(N_ELEC), .IDX_W(IDX_W)) step_i (
    .cur_drv    (drv_idx),
    .cur_meas   (meas_idx),
    .nxt_drv    (nxt_drv),
    .nxt_meas   (nxt_meas),
    .drive_last (drive_last),
    .frame_last (frame_last)
  );

  assign finishing = frame_last && (stop_pend_q || stop_cmd);
  assign tmr_load  = ((state_q == ST_IDLE) && start_cmd) ||
                     ((state_q == ST_WAIT) && meas_done && !finishing);

  eit_settle_timer #(.CNT_W(SETTLE_W)) timer_i (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (settle_cycles),
    .run      (state_q == ST_SETTLE),
    .expired  (tmr_expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      stop_pend_q <= 1'b0;
      drv_idx     <= '0;
      meas_idx    <= '0;
      meas_start  <= 1'b0;
      frame_start <= 1'b0;
      busy        <= 1'b0;
    end else begin
      meas_start  <= 1'b0;
      frame_start <= 1'b0;
      if ((state_q != ST_IDLE) && stop_cmd) stop_pend_q <= 1'b1;
      unique case (state_q)
        ST_IDLE: begin
          if (start_cmd) begin
            drv_idx     <= FIRST_DRV;
            meas_idx    <= FIRST_MEAS;
            busy        <= 1'b1;
            stop_pend_q <= 1'b0;
            state_q     <= ST_SETTLE;
          end
        end
        ST_SETTLE: begin
          if (tmr_expired) begin
            meas_start  <= 1'b1;
            frame_start <= (drv_idx == FIRST_DRV) && (meas_idx == FIRST_MEAS);
            state_q     <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (meas_done) begin
            if (finishing) begin
              busy        <= 1'b0;
              stop_pend_q <= 1'b0;
              state_q     <= ST_IDLE;
            end else begin
              drv_idx  <= nxt_drv;
              meas_idx <= nxt_meas;
              state_q  <= ST_SETTLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eit_scan_seq_chk.sv
module eit_scan_seq_chk #(
  parameter int N_ELEC   = 16,
  parameter int IDX_W    = $clog2(N_ELEC),
  parameter int SETTLE_W = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                start_cmd,
  input logic                stop_cmd,
  input logic [SETTLE_W-1:0] settle_cycles,
  input logic                meas_done,
  input logic [IDX_W-1:0]    drv_idx,
  input logic [IDX_W-1:0]    meas_idx,
  input logic                meas_start,
  input logic                frame_start,
  input logic                busy
);
  int sep;
  always_comb sep = (int'(meas_idx) + N_ELEC - int'(drv_idx)) % N_ELEC;

  // R3
  pair_disjoint_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (sep >= 2) && (sep <= N_ELEC - 2));

  // R6
  pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    meas_start |=> !meas_start);

  // R7
  frame_flag_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> meas_start && (drv_idx == '0) && (meas_idx == IDX_W'(2)));

  // R9
  stop_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(meas_done) && ($past(drv_idx) == IDX_W'(N_ELEC - 1)) &&
                    ($past(meas_idx) == IDX_W'(N_ELEC - 3)));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !meas_start);

  // R11
  hold_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (meas_start && !meas_done) |=> $stable(drv_idx) && $stable(meas_idx));
endmodule

bind eit_scan_seq eit_scan_seq_chk #(
  .N_ELEC(N_ELEC), .IDX_W(IDX_W), .SETTLE_W(SETTLE_W)
) chk_i (
  .clk(clk), .rst(rst), .start_cmd(start_cmd), .stop_cmd(stop_cmd),
  .settle_cycles(settle_cycles), .meas_done(meas_done), .drv_idx(drv_idx),
  .meas_idx(meas_idx), .meas_start(meas_start), .frame_start(frame_start),
  .busy(busy)
);

// File: tb/eit_scan_seq_tb_top.sv
module eit_scan_seq_tb_top;
  localparam int NE = 16;
  localparam int IW = 4;
  localparam int SW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_cmd = 1'b0;
  logic          stop_cmd = 1'b0;
  logic [SW-1:0] settle_cycles = '0;
  logic          meas_done = 1'b0;
  logic [IW-1:0] drv_idx, meas_idx;
  logic          meas_start, frame_start, busy;

  int tests = 0;
  int fails = 0;
  int exp_d = 0;
  int exp_m = 2;
  bit wrapped = 1'b0;

  always #2.5 clk = ~clk;

  eit_scan_seq #(.N_ELEC(NE), .IDX_W(IW), .SETTLE_W(SW)) dut_i (
    .clk(clk), .rst(rst), .start_cmd(start_cmd), .stop_cmd(stop_cmd),
    .settle_cycles(settle_cycles), .meas_done(meas_done), .drv_idx(drv_idx),
    .meas_idx(meas_idx), .meas_start(meas_start), .frame_start(frame_start),
    .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Expected ordering from R3/R4, independent of the design.
  task automatic model_advance();
    wrapped = 1'b0;
    if (exp_m == (exp_d + NE - 2) % NE) begin
      if (exp_d == NE - 1) wrapped = 1'b1;
      exp_d = (exp_d + 1) % NE;
      exp_m = (exp_d + 2) % NE;
    end else begin
      exp_m = (exp_m + 1) % NE;
    end
  endtask

  // Waits for the next request, checks it, then answers with a done strobe.
  task automatic serve_one(input int s, input bit spur);
    int cnt = 0;
    bit seen = 1'b0;
    while (!seen && cnt < s + 50) begin
      @(posedge clk);
      @(negedge clk);
      start_cmd = 1'b0;
      stop_cmd  = 1'b0;
      meas_done = (spur && cnt == 0);
      cnt++;
      seen = meas_start;
    end
    meas_done = 1'b0;
    chk(cnt == s + 2, "R5 settle gap", cnt, s + 2);
    chk(int'(drv_idx) == exp_d && int'(meas_idx) == exp_m, "R3 R4 selection",
        int'(drv_idx) * 100 + int'(meas_idx), exp_d * 100 + exp_m);
    chk(frame_start == (exp_d == 0 && exp_m == 2), "R7 frame flag",
        int'(frame_start), int'(exp_d == 0 && exp_m == 2));
    meas_done = 1'b1;
    model_advance();
  endtask

  task automatic begin_run(input int s);
    @(negedge clk);
    settle_cycles = SW'(s);
    start_cmd = 1'b1;
    exp_d = 0;
    exp_m = 2;
  endtask

  task automatic serve_to_frame_end(input int s);
    int guard = 0;
    do begin
      serve_one(s, 1'b0);
      guard++;
    end while (!wrapped && guard < 300);
  endtask

  task automatic check_stopped(input int s);
    int pulses = 0;
    @(posedge clk);
    @(negedge clk);
    meas_done = 1'b0;
    chk(busy == 1'b0, "R9 busy after last done", int'(busy), 0);
    for (int i = 0; i < s + 10; i++) begin
      @(negedge clk);
      if (meas_start) pulses++;
    end
    chk(pulses == 0, "R9 no request after stop", pulses, 0);
  endtask

  task automatic t_reset();
    chk(busy == 0 && meas_start == 0 && frame_start == 0, "R1 flags", int'(busy), 0);
    chk(drv_idx == 0 && meas_idx == 0, "R1 indices", int'(drv_idx) * 100 + int'(meas_idx), 0);
  endtask

  task automatic t_idle_stop();
    @(negedge clk);
    stop_cmd = 1'b1;
    @(negedge clk);
    stop_cmd = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy == 0 && meas_start == 0, "R10 stop while idle", int'(busy), 0);
  endtask

  task automatic t_full_frame();
    begin_run(2);
    serve_one(2, 1'b0);
    chk(exp_d == 0 && exp_m == 3, "R2 first reading consumed", exp_d * 100 + exp_m, 3);
    serve_to_frame_end(2);
    chk(busy == 1'b1, "R8 still running at frame end", int'(busy), 1);
    for (int i = 0; i < 20; i++) serve_one(2, 1'b0); // R8: next frame starts at 0/2
  endtask

  task automatic t_spurious();
    for (int i = 0; i < 3; i++) serve_one(2, 1'b1); // R6: done while settling ignored
  endtask

  task automatic t_start_busy();
    start_cmd = 1'b1;  // R10: start while busy ignored
    serve_one(2, 1'b0);
    serve_one(2, 1'b0);
  endtask

  task automatic t_stop_mid();
    stop_cmd = 1'b1;   // R9: stop mid frame
    serve_one(2, 1'b0);
    chk(busy == 1'b1, "R9 frame not cut short", int'(busy), 1);
    serve_to_frame_end(2);
    check_stopped(2);
  endtask

  task automatic t_settle_zero();
    begin_run(0);
    for (int i = 0; i < 15; i++) serve_one(0, 1'b0);
    stop_cmd = 1'b1;
    serve_to_frame_end(0);
    check_stopped(0);
  endtask

  task automatic t_long_settle();
    begin_run(9);
    for (int i = 0; i < 4; i++) serve_one(9, 1'b0);
    stop_cmd = 1'b1;
    serve_to_frame_end(9);
    check_stopped(9);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_idle_stop();
    t_full_frame();
    t_spurious();
    t_start_busy();
    t_stop_mid();
    t_settle_zero();
    t_long_settle();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule